// File: doc/BRIEF.md
# Serial-Controlled SAR Converter Control Logic

This block is the digital control for a 10-bit successive-approximation converter behind a serial host link. All logic runs on one system clock. The host inputs (active-low chip select, I/O clock and serial address line) are sampled into that clock domain.

A frame is ten I/O clocks long. In each frame the block shifts in a 4-bit channel address and shifts out the result of the previous conversion. The tenth falling I/O clock edge starts a conversion on the addressed channel. The conversion takes a fixed 44 system clocks. The block drives the multiplexer channel code, the sample/hold control and the DAC trial code, and it reads a 1-bit comparator decision. The data output comes with a separate enable, so a pad driver outside the block can produce the high-impedance state.

The multiplexer, the DAC and the comparator lie outside the block. The comparator reports 1 when the sampled input is at or above the current DAC code.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset, `dout_en`, `sample_hold`, `done`, `ch_sel` and `dac_code` are all zero, and the stored result is zero. The first frame therefore reads out 0.
- R2: `dout_en` is low once `cs_n` has been high for three system clocks. It is high while the synchronized chip select is low.
- R3: When chip select goes low, `dout` shows bit 9 of the stored result before any I/O clock edge. Each of the first nine falling I/O clock edges moves `dout` to the next lower bit.
- R4: Address bits are taken on rising I/O clock edges, MSB first. Only the first four bits of a frame count, and later bits are ignored.
- R5: The tenth falling I/O clock edge of a frame starts a conversion and loads `ch_sel` from the address. Codes 0 to 10 select that channel, and codes 11 to 15 all select the self-test channel, code 11.
- R6: I/O clock edges that arrive within three system clocks after a chip-select fall is detected are ignored.
- R7: The conversion lasts 44 system clocks. `sample_hold` is high for the first 4. The next 40 resolve bits 9 down to 0 at 4 clocks per bit: the trial bit is set, and the comparator decides whether it stays. A one-cycle `done` pulse ends the conversion, and the final code becomes the stored result.
- R8: I/O clock edges during a conversion are ignored. If chip select stays low, a new frame starts after `done`, and `dout` shows the new result's MSB.
- R9: A chip-select rise before the tenth falling edge aborts the frame. No conversion runs, and `ch_sel` and the stored result are unchanged.
- R10: A chip-select rise during a conversion does not stop the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| io_clk | input | 1 | Host I/O clock, asynchronous |
| addr_in | input | 1 | Serial channel address from the host |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above the DAC code |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Drive enable for the data pad; low means high impedance |
| ch_sel | output | 4 | Analog multiplexer channel code (0 to 11) |
| sample_hold | output | 1 | High while the input is being sampled |
| dac_code | output | 10 | DAC trial code |
| done | output | 1 | One-cycle pulse when a result is stored |

## Verification
The bench checks that only the first four address bits count, by driving ones after them. A design that latched the last four bits would turn address 0 into the self-test channel.

An I/O clock pulse placed inside the chip-select guard window would, if it were counted, advance `dout` early and corrupt the captured address. Holding chip select low through a conversion while toggling the I/O clock catches a design that counts those edges: it would shift out a misaligned next result. An aborted frame followed by a full frame catches a design that starts a conversion anyway, or that keeps a stale bit count.

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 4,
  parameter int FRAME_LEN   = 10,
  parameter int GUARD_CYC   = 3,
  parameter int SAMPLE_CYC  = 4,
  parameter int CYC_PER_BIT = 4,
  parameter int EXT_CH      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              io_clk,
  input  logic              addr_in,
  input  logic              cmp_in,
  output logic              dout,
  output logic              dout_en,
  output logic [ADDR_W-1:0] ch_sel,
  output logic              sample_hold,
  output logic [DATA_W-1:0] dac_code,
  output logic              done
);
  localparam int CONV_CYC = SAMPLE_CYC + DATA_W * CYC_PER_BIT;
  localparam int CNT_W    = $clog2(CONV_CYC + 1);
  localparam int FCNT_W   = $clog2(FRAME_LEN + 1);
  localparam int GCNT_W   = $clog2(GUARD_CYC + 1);
  localparam int ACNT_W   = $clog2(ADDR_W + 1);
  localparam int PH_W     = $clog2(CYC_PER_BIT);
  localparam int BIT_W    = $clog2(DATA_W);

  logic [1:0] cs_sync, io_sync;
  logic       cs_d, io_d;
  logic [GCNT_W-1:0] guard;
  logic [FCNT_W-1:0] fcnt;
  logic [ACNT_W-1:0] acnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] sh, result, dac_next;
  logic              busy;
  logic [CNT_W-1:0]  ccnt;
  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bpos;

  wire cs_s    = cs_sync[1];
  wire io_s    = io_sync[1];
  wire cs_fall = cs_d & ~cs_s;
  wire cs_rise = ~cs_d & cs_s;
  wire io_rise = io_s & ~io_d;
  wire io_fall = ~io_s & io_d;
  wire active  = ~cs_s & (guard == '0) & ~busy & ~cs_fall;
  wire start   = active & io_fall & (fcnt == FCNT_W'(FRAME_LEN - 1));
  wire sampling = ccnt < CNT_W'(SAMPLE_CYC);
  wire trial   = busy & ~sampling & (ph == '0);
  wire decide  = busy & ~sampling & (ph == PH_W'(CYC_PER_BIT - 1));
  wire last    = busy & (ccnt == CNT_W'(CONV_CYC - 1));
  wire [ADDR_W-1:0] ch_map = (addr_sh >= ADDR_W'(EXT_CH)) ? ADDR_W'(EXT_CH) : addr_sh;

  assign dout        = sh[DATA_W-1];
  assign dout_en     = ~cs_s;
  assign sample_hold = busy & sampling;

  always_comb begin
    dac_next = dac_code;
    if (decide)     dac_next[bpos] = cmp_in;
    else if (trial) dac_next[bpos] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync <= 2'b11;
      io_sync <= 2'b00;
      cs_d    <= 1'b1;
      io_d    <= 1'b0;
    end else begin
      cs_sync <= {cs_sync[0], cs_n};
      io_sync <= {io_sync[0], io_clk};
      cs_d    <= cs_s;
      io_d    <= io_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard <= '0; fcnt <= '0; acnt <= '0; addr_sh <= '0;
      sh <= '0; result <= '0; busy <= 1'b0; ccnt <= '0;
      ph <= '0; bpos <= '0; ch_sel <= '0; dac_code <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (guard != '0) guard <= guard - 1'b1;
      if (cs_s) sh <= result;
      if (cs_fall) begin
        guard <= GCNT_W'(GUARD_CYC);
        fcnt  <= '0;
        acnt  <= '0;
      end else if (cs_rise && !busy) begin
        fcnt <= '0;
        acnt <= '0;
      end else if (active) begin
        if (io_rise && acnt < ACNT_W'(ADDR_W)) begin
          addr_sh <= {addr_sh[ADDR_W-2:0], addr_in};
          acnt    <= acnt + 1'b1;
        end
        if (io_fall) begin
          sh <= {sh[DATA_W-2:0], 1'b0};
          if (start) begin
            busy     <= 1'b1;
            ccnt     <= '0;
            ph       <= '0;
            bpos     <= BIT_W'(DATA_W - 1);
            ch_sel   <= ch_map;
            dac_code <= '0;
            fcnt     <= '0;
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end
      end
      if (busy) begin
        ccnt     <= ccnt + 1'b1;
        dac_code <= dac_next;
        if (!sampling) ph <= ph + 1'b1;
        if (decide && bpos != '0) bpos <= bpos - 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= dac_next;
          sh     <= dac_next;
          fcnt   <= '0;
          acnt   <= '0;
        end
      end
    end
  end

  a_r2_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !dout_en);
  a_r5_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ch_sel <= ADDR_W'(EXT_CH));
  a_r5_ch_moves_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_sel) |-> $rose(busy));
  a_r7_sample_opens_conversion: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sample_hold);
  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_ends_conversion: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
  a_r9_abort_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !busy |=> !busy);
endmodule

// File: tb/sim_sar_serial_ctrl.sv
module sim_sar_serial_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, io_clk = 1'b0, addr_in = 1'b0;
  logic cmp_in, dout, dout_en, sample_hold, done;
  logic [3:0] ch_sel;
  logic [9:0] dac_code;
  int nchk = 0, nfail = 0, done_cnt = 0, sh_cnt = 0, prev = 0;

  always #4 clk = ~clk;

  function automatic int vin(input int c);
    case (c)
      11: return 512;
      7:  return 1023;
      3:  return 0;
      default: return (c * 97 + 13) % 1024;
    endcase
  endfunction

  assign cmp_in = vin(int'(ch_sel)) >= int'(dac_code);

  sar_serial_ctrl u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk),
    .addr_in(addr_in), .cmp_in(cmp_in), .dout(dout), .dout_en(dout_en),
    .ch_sel(ch_sel), .sample_hold(sample_hold), .dac_code(dac_code), .done(done));

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (sample_hold) sh_cnt <= sh_cnt + 1;
  end

  localparam logic [3:0] V_ADDR [8] = '{4'd0, 4'd5, 4'd10, 4'd11, 4'd13, 4'd15, 4'd3, 4'd7};
  localparam logic [3:0] V_CH   [8] = '{4'd0, 4'd5, 4'd10, 4'd11, 4'd11, 4'd11, 4'd3, 4'd7};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic io_pulse(input logic a);
    addr_in = a; io_clk = 1'b1; tick(4);
    io_clk = 1'b0; tick(4);
  endtask

  task automatic cs_low();  cs_n = 1'b0; tick(6); endtask
  task automatic cs_high(); cs_n = 1'b1; tick(4); endtask

  task automatic frame(input logic [3:0] addr, input int exp_prev);
    check(dout_en == 1'b1, "R2 enable", int'(dout_en), 1);
    check(dout == exp_prev[9], "R3 msb first", int'(dout), int'(exp_prev[9]));
    for (int i = 0; i < 10; i++) begin
      io_pulse(i < 4 ? addr[3 - i] : 1'b1);
      if (i < 9) check(dout == exp_prev[8 - i], "R3 shift out", int'(dout), int'(exp_prev[8 - i]));
    end
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    check(dout_en == 1'b0, "R1 dout_en", int'(dout_en), 0);
    check(ch_sel == 4'd0, "R1 ch_sel", int'(ch_sel), 0);
    check(sample_hold == 1'b0, "R1 sample_hold", int'(sample_hold), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(dac_code == 10'd0, "R1 dac_code", int'(dac_code), 0);

    for (int k = 0; k < 8; k++) begin
      int d0, s0;
      d0 = done_cnt; s0 = sh_cnt;
      cs_low();
      frame(V_ADDR[k], prev);
      check(ch_sel == V_CH[k], "R4 R5 channel", int'(ch_sel), int'(V_CH[k]));
      cs_high();
      tick(50);
      check(done_cnt - d0 == 1, "R7 R10 one done", done_cnt - d0, 1);
      check(sh_cnt - s0 == 4, "R7 sample cycles", sh_cnt - s0, 4);
      check(int'(dac_code) == vin(int'(V_CH[k])), "R7 result", int'(dac_code), vin(int'(V_CH[k])));
      check(dout_en == 1'b0, "R2 hiz", int'(dout_en), 0);
      prev = vin(int'(V_CH[k]));
    end

    // R8: chip select held low through conversion, I/O clock toggling
    cs_low();
    frame(4'd2, prev);
    check(ch_sel == 4'd2, "R8 channel", int'(ch_sel), 2);
    for (int j = 0; j < 3; j++) io_pulse(1'b1);
    tick(30);
    prev = vin(2);
    check(dout == prev[9], "R8 new msb", int'(dout), int'(prev[9]));
    frame(4'd6, prev);
    check(ch_sel == 4'd6, "R8 next channel", int'(ch_sel), 6);
    cs_high();
    tick(50);
    prev = vin(6);

    // R9: abort after five I/O clocks
    begin
      int d0;
      d0 = done_cnt;
      cs_low();
      io_pulse(1'b1); io_pulse(1'b0); io_pulse(1'b0); io_pulse(1'b1); io_pulse(1'b0);
      cs_high();
      tick(60);
      check(done_cnt == d0, "R9 no conversion", done_cnt - d0, 0);
      check(ch_sel == 4'd6, "R9 channel kept", int'(ch_sel), 6);
      cs_low();
      frame(4'd1, prev);
      cs_high();
      tick(50);
      prev = vin(1);
    end

    // R6: I/O clock pulse inside the guard window
    cs_n = 1'b0; tick(1);
    addr_in = 1'b1; io_clk = 1'b1; tick(1);
    io_clk = 1'b0; tick(6);
    check(dout == prev[9], "R6 guard no shift", int'(dout), int'(prev[9]));
    frame(4'd4, prev);
    check(ch_sel == 4'd4, "R6 guard no capture", int'(ch_sel), 4);
    cs_high();
    tick(50);
    check(int'(dac_code) == vin(4), "R7 result after guard", int'(dac_code), vin(4));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule